// File: doc/BRIEF.md
# Serial Frequency Command Interpreter

This block turns a stream of received ASCII bytes into control of a frequency setting held in kHz. It sits between a serial receiver and a serial transmitter, which lie outside it. The receiver hands it one byte at a time over a valid/ready pair, and it sends its replies to the transmitter over a second valid/ready pair. Each command is a line of uppercase characters that ends in carriage return (0x0D). A decimal number followed by `M`, by `K` or by nothing sets the frequency in MHz or kHz. `READ` reports the current setting. `SAVE` raises a one-cycle strobe so that storage outside the block can keep the value.

The host sees every character it types echoed back. After an accepted command the block sends the prompt `*`, and after a rejected one it sends an error line. The prompt is the only flow control: the host waits for it before it sends the next line. Any line whose first character is `$` is meant for a different unit on the same wire. The interpreter consumes such a line without reacting to it.

Top module: `freq_cmd_parser`

## Requirements
- R1: Every byte of a line whose first character is not `$` is echoed on the transmit side unchanged, in arrival order, including the closing carriage return, and all of these echoes come before any reply to that line.
- R2: A line of 1 to 7 decimal digits followed by `M` sets the frequency to that value times 1000 kHz, and the reply is the single byte `*` (0x2A).
- R3: A line of 1 to 7 decimal digits followed by `K`, or by nothing at all, sets the frequency to that value in kHz, and the reply is `*`. Leading zeros are allowed.
- R4: A numeric line with more than 7 digits, or one whose kHz value falls below 50000 or above 3000000, is rejected and leaves the frequency unchanged. Both range limits are accepted values.
- R5: A rejected line is answered with the 12 characters `INVALID DATA`, then 0x0D, 0x0A and `*`. Lowercase letters, an empty line, a unit letter that is not last, a unit letter without digits, and any unknown word are all rejected.
- R6: `READ` is answered with the current kHz value as exactly 7 decimal digits with leading zeros, then `KHz`, 0x0D, 0x0A and `*`. The frequency does not change.
- R7: `SAVE` is answered with `*` and raises `save_pulse` for exactly one clock cycle. The frequency does not change.
- R8: A line whose first character is `$` (0x24) produces no transmit byte at all, up to and including its carriage return, and changes neither the frequency nor `save_pulse`.
- R9: A line of more than 12 characters before its carriage return is rejected as in R5.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. `rx_ready` is never high in a cycle in which `tx_valid` is high.
- R11: After reset the frequency is 1000000 kHz, `tx_valid` and `save_pulse` are low and `rx_ready` is high.
- R12: In the cycle after a `*` byte is taken by the transmitter, `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Interpreter can take a received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| freq_khz | output | 22 | Current frequency setting in kHz |
| save_pulse | output | 1 | One-cycle strobe requesting storage of the setting |

## Verification
Numbers are sent with each of the three unit forms, with leading zeros, and at the exact range limits and one step beyond them. This separates the MHz scaling, the kHz path and the comparison bounds. Malformed lines test the shape checks one at a time: lowercase text, an empty line, a misplaced unit, a bare unit letter, too many digits, and lines over the length limit (one just over it and one long enough to saturate the length count). Lines meant for the other unit are placed between normal commands, so any stray echo or state change shows up in the next reply. The transmitter's ready signal is driven with three duty patterns, so that echo and reply bytes are checked both with back-pressure and without it.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;
    localparam logic [7:0] CH_STAR   = 8'h2A;
    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_ZERO   = 8'h30;
    localparam logic [7:0] CH_M      = 8'h4D;
    localparam logic [7:0] CH_K      = 8'h4B;
    localparam logic [7:0] CH_H      = 8'h48;
    localparam logic [7:0] CH_Z_LO   = 8'h7A;

    // Four-letter command words, first letter in the top byte
    localparam logic [31:0] WORD_REPORT = 32'h5245_4144;
    localparam logic [31:0] WORD_STORE  = 32'h5341_5645;

    localparam int BAD_LEN = 15;

    typedef enum logic [1:0] {
        RSP_ACK,
        RSP_BAD,
        RSP_REPORT
    } rsp_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ECHO,
        ST_EVAL,
        ST_CONV,
        ST_RESP
    } ctl_state_e;

    typedef struct packed {
        logic        num_shape_ok;
        logic        has_unit;
        logic        unit_mhz;
        logic        too_many;
        logic [31:0] tail;
    } scan_flags_t;

    function automatic logic is_digit(input logic [7:0] c);
        return (c >= 8'h30) && (c <= 8'h39);
    endfunction

    function automatic logic [39:0] dec_weight(input int n);
        logic [39:0] w;
        w = 40'd1;
        for (int i = 0; i < n; i++) begin
            w = w * 40'd10;
        end
        return w;
    endfunction

    // Error reply: text, CR, LF, prompt
    function automatic logic [7:0] bad_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'h49;
            4'd1:    return 8'h4E;
            4'd2:    return 8'h56;
            4'd3:    return 8'h41;
            4'd4:    return 8'h4C;
            4'd5:    return 8'h49;
            4'd6:    return 8'h44;
            4'd7:    return 8'h20;
            4'd8:    return 8'h44;
            4'd9:    return 8'h41;
            4'd10:   return 8'h54;
            4'd11:   return 8'h41;
            4'd12:   return CH_CR;
            4'd13:   return CH_LF;
            default: return CH_STAR;
        endcase
    endfunction

endpackage

// File: rtl/fcp_line_scan.sv
module fcp_line_scan
    import fcp_pkg::*;
#(
    parameter int MAX_DIGITS = 7,
    parameter int MAX_LEN    = 12,
    parameter int ACC_W      = 24,
    parameter int CNT_W      = 3,
    parameter int LEN_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic [7:0]       ch,
    output logic [ACC_W-1:0] acc,
    output logic [CNT_W-1:0] ndig,
    output logic [LEN_W-1:0] len,
    output scan_flags_t      flags
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc                <= '0;
            ndig               <= '0;
            len                <= '0;
            flags.num_shape_ok <= 1'b1;
            flags.has_unit     <= 1'b0;
            flags.unit_mhz     <= 1'b0;
            flags.too_many     <= 1'b0;
            flags.tail         <= '0;
        end else if (take) begin
            flags.tail <= {flags.tail[23:0], ch};
            // length saturates one past the limit
            if (len <= LEN_W'(MAX_LEN)) begin
                len <= len + 1'b1;
            end
            if (flags.has_unit) begin
                flags.num_shape_ok <= 1'b0;
            end else if (is_digit(ch)) begin
                if (ndig == CNT_W'(MAX_DIGITS)) begin
                    flags.too_many <= 1'b1;
                end else begin
                    acc  <= ACC_W'(acc * 4'd10) + ACC_W'(ch[3:0]);
                    ndig <= ndig + 1'b1;
                end
            end else if (((ch == CH_M) || (ch == CH_K)) && (ndig != '0)) begin
                flags.has_unit <= 1'b1;
                flags.unit_mhz <= (ch == CH_M);
            end else begin
                flags.num_shape_ok <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fcp_dec_conv.sv
module fcp_dec_conv
    import fcp_pkg::*;
#(
    parameter int NDIG   = 7,
    parameter int FREQ_W = 22
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FREQ_W-1:0]     value,
    output logic                  done,
    output logic [NDIG-1:0][3:0]  digits
);

    localparam int PW    = 40;
    localparam int POS_W = $clog2(NDIG + 1);

    logic [PW-1:0]    wtab [NDIG];
    logic [PW-1:0]    rem;
    logic [PW-1:0]    weight;
    logic [POS_W-1:0] pos;
    logic [3:0]       cnt;
    logic             busy;

    // Place weights, most significant position first
    for (genvar g = 0; g < NDIG; g++) begin : g_weight
        assign wtab[g] = dec_weight(NDIG - 1 - g);
    end

    assign weight = wtab[pos];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            rem    <= '0;
            pos    <= '0;
            cnt    <= '0;
            digits <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                rem  <= PW'(value);
                pos  <= '0;
                cnt  <= '0;
            end else if (busy) begin
                if (rem >= weight) begin
                    rem <= rem - weight;
                    cnt <= cnt + 1'b1;
                end else begin
                    digits[pos] <= cnt;
                    cnt         <= '0;
                    if (pos == POS_W'(NDIG - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fcp_resp_gen.sv
module fcp_resp_gen
    import fcp_pkg::*;
#(
    parameter int NDIG = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  rsp_kind_e            kind,
    input  logic [NDIG-1:0][3:0] digits,
    input  logic                 tx_ready,
    output logic                 valid,
    output logic [7:0]           data,
    output logic                 last_beat
);

    localparam int MAXL  = (BAD_LEN > NDIG + 6) ? BAD_LEN : NDIG + 6;
    localparam int IDX_W = $clog2(MAXL + 1);

    rsp_kind_e        kind_q;
    logic [IDX_W-1:0] idx;
    logic             busy;
    logic             final_b;
    logic [3:0]       dsel;

    always_comb begin
        dsel = '0;
        for (int i = 0; i < NDIG; i++) begin
            if (idx == IDX_W'(i)) dsel = digits[i];
        end
    end

    always_comb begin
        data    = CH_STAR;
        final_b = 1'b1;
        unique case (kind_q)
            RSP_ACK: begin
                data    = CH_STAR;
                final_b = 1'b1;
            end
            RSP_BAD: begin
                data    = bad_byte(4'(idx));
                final_b = (idx == IDX_W'(BAD_LEN - 1));
            end
            RSP_REPORT: begin
                final_b = (idx == IDX_W'(NDIG + 5));
                if (idx < IDX_W'(NDIG))            data = CH_ZERO | {4'h0, dsel};
                else if (idx == IDX_W'(NDIG))      data = CH_K;
                else if (idx == IDX_W'(NDIG + 1))  data = CH_H;
                else if (idx == IDX_W'(NDIG + 2))  data = CH_Z_LO;
                else if (idx == IDX_W'(NDIG + 3))  data = CH_CR;
                else if (idx == IDX_W'(NDIG + 4))  data = CH_LF;
                else                               data = CH_STAR;
            end
            default: begin
                data    = CH_STAR;
                final_b = 1'b1;
            end
        endcase
    end

    assign valid     = busy;
    assign last_beat = busy && tx_ready && final_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            kind_q <= RSP_ACK;
        end else if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            kind_q <= kind;
        end else if (busy && tx_ready) begin
            if (final_b) busy <= 1'b0;
            else         idx  <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/freq_cmd_parser.sv
module freq_cmd_parser
    import fcp_pkg::*;
#(
    parameter int MAX_DIGITS = 7,
    parameter int MAX_LEN    = 12,
    parameter int FREQ_W     = 22,
    parameter int MIN_KHZ    = 50000,
    parameter int MAX_KHZ    = 3000000,
    parameter int RESET_KHZ  = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [FREQ_W-1:0] freq_khz,
    output logic              save_pulse
);

    localparam int ACC_W   = $clog2(10 ** MAX_DIGITS);
    localparam int SCALE_W = ACC_W + 10;
    localparam int CNT_W   = $clog2(MAX_DIGITS + 1);
    localparam int LEN_W   = $clog2(MAX_LEN + 2);

    ctl_state_e               state;
    logic [7:0]               echo_q;
    logic [ACC_W-1:0]         acc;
    logic [CNT_W-1:0]         ndig;
    logic [LEN_W-1:0]         len;
    scan_flags_t              flags;
    logic                     rx_take;
    logic                     line_start_foreign;
    logic                     scan_take;
    logic                     scan_clr;
    logic [SCALE_W-1:0]       scaled;
    logic                     in_range;
    logic                     num_good;
    logic                     is_report;
    logic                     is_store;
    logic                     conv_start;
    logic                     conv_done;
    logic [MAX_DIGITS-1:0][3:0] digits;
    logic                     resp_start;
    rsp_kind_e                resp_kind;
    logic                     resp_valid;
    logic [7:0]               resp_data;
    logic                     resp_last;

    assign rx_ready           = (state == ST_IDLE) || (state == ST_SKIP);
    assign rx_take            = rx_valid && rx_ready;
    assign line_start_foreign = (rx_data == CH_DOLLAR) && (len == '0);
    assign scan_take          = (state == ST_IDLE) && rx_take &&
                                (rx_data != CH_CR) && !line_start_foreign;
    assign scan_clr           = (state == ST_EVAL);

    fcp_line_scan #(
        .MAX_DIGITS (MAX_DIGITS),
        .MAX_LEN    (MAX_LEN),
        .ACC_W      (ACC_W),
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W)
    ) u_scan (
        .clk   (clk),
        .rst   (rst),
        .clr   (scan_clr),
        .take  (scan_take),
        .ch    (rx_data),
        .acc   (acc),
        .ndig  (ndig),
        .len   (len),
        .flags (flags)
    );

    // Verdict on a completed line
    always_comb begin
        scaled    = flags.unit_mhz ? SCALE_W'(acc) * SCALE_W'(1000) : SCALE_W'(acc);
        in_range  = (scaled >= SCALE_W'(MIN_KHZ)) && (scaled <= SCALE_W'(MAX_KHZ));
        num_good  = flags.num_shape_ok && (ndig != '0) && !flags.too_many &&
                    (len <= LEN_W'(MAX_LEN)) && in_range;
        is_report = (len == LEN_W'(4)) && (flags.tail == WORD_REPORT);
        is_store  = (len == LEN_W'(4)) && (flags.tail == WORD_STORE);
    end

    assign conv_start = (state == ST_EVAL) && is_report;
    assign resp_start = ((state == ST_EVAL) && !is_report) ||
                        ((state == ST_CONV) && conv_done);

    always_comb begin
        if (state == ST_CONV)          resp_kind = RSP_REPORT;
        else if (num_good || is_store) resp_kind = RSP_ACK;
        else                           resp_kind = RSP_BAD;
    end

    fcp_dec_conv #(
        .NDIG   (MAX_DIGITS),
        .FREQ_W (FREQ_W)
    ) u_conv (
        .clk    (clk),
        .rst    (rst),
        .start  (conv_start),
        .value  (freq_khz),
        .done   (conv_done),
        .digits (digits)
    );

    fcp_resp_gen #(
        .NDIG (MAX_DIGITS)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .start     (resp_start),
        .kind      (resp_kind),
        .digits    (digits),
        .tx_ready  (tx_ready),
        .valid     (resp_valid),
        .data      (resp_data),
        .last_beat (resp_last)
    );

    assign tx_valid = (state == ST_ECHO) || resp_valid;
    assign tx_data  = (state == ST_ECHO) ? echo_q : resp_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            echo_q     <= '0;
            freq_khz   <= FREQ_W'(RESET_KHZ);
            save_pulse <= 1'b0;
        end else begin
            save_pulse <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rx_take) begin
                        if (line_start_foreign) begin
                            state <= ST_SKIP;
                        end else begin
                            echo_q <= rx_data;
                            state  <= ST_ECHO;
                        end
                    end
                end
                ST_SKIP: begin
                    if (rx_take && (rx_data == CH_CR)) state <= ST_IDLE;
                end
                ST_ECHO: begin
                    if (tx_ready) state <= (echo_q == CH_CR) ? ST_EVAL : ST_IDLE;
                end
                ST_EVAL: begin
                    if (is_report) begin
                        state <= ST_CONV;
                    end else begin
                        state <= ST_RESP;
                        if (num_good) freq_khz   <= FREQ_W'(scaled);
                        if (is_store) save_pulse <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (conv_done) state <= ST_RESP;
                end
                ST_RESP: begin
                    if (resp_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcp_checker.sv
module fcp_checker #(
    parameter int FREQ_W  = 22,
    parameter int MIN_KHZ = 50000,
    parameter int MAX_KHZ = 3000000
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic [FREQ_W-1:0] freq_khz,
    input logic              save_pulse
);

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_rx_tx_excl_r10: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> !tx_valid);

    p_freq_range_r4: assert property (@(posedge clk) disable iff (rst)
        (freq_khz >= FREQ_W'(MIN_KHZ)) && (freq_khz <= FREQ_W'(MAX_KHZ)));

    p_save_single_r7: assert property (@(posedge clk) disable iff (rst)
        save_pulse |=> !save_pulse);

    p_prompt_ready_r12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && (tx_data == 8'h2A)) |=> rx_ready);

endmodule

bind freq_cmd_parser fcp_checker #(
    .FREQ_W  (FREQ_W),
    .MIN_KHZ (MIN_KHZ),
    .MAX_KHZ (MAX_KHZ)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .freq_khz   (freq_khz),
    .save_pulse (save_pulse)
);

// File: tb/sim_freq_cmd_parser.sv
module sim_freq_cmd_parser;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic [21:0] freq_khz;
    logic        save_pulse;

    always #2 clk = ~clk;

    freq_cmd_parser u0 (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .freq_khz   (freq_khz),
        .save_pulse (save_pulse)
    );

    int          checks = 0;
    int          errors = 0;
    byte unsigned exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R11";
    int          model_freq = 1000000;
    int          model_saves = 0;
    int          seen_saves = 0;
    int          rdy_mode = 0;
    int          cyc = 0;
    bit          prev_stall = 0;
    bit          prev_star = 0;
    logic [7:0]  prev_data = 8'h00;
    byte unsigned mon_e;
    string       mon_t;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Transmitter back-pressure patterns
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0:       tx_ready = 1'b1;
            1:       tx_ready = (cyc % 3) != 0;
            default: tx_ready = (cyc % 7) < 2;
        endcase
    end

    // Reference comparison every clock
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (prev_stall)
                check(tx_valid && (tx_data == prev_data), "R10", "tx hold while stalled", tx_data, prev_data);
            if (prev_star)
                check(rx_ready == 1'b1, "R12", "rx_ready after prompt", rx_ready, 1);
            if (rx_ready && tx_valid)
                check(1'b0, "R10", "rx_ready together with tx_valid", 1, 0);
            if (save_pulse) seen_saves++;
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected tx byte", tx_data, -1);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    check(tx_data == mon_e, mon_t, "tx byte", tx_data, mon_e);
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_star  = tx_valid && tx_ready && (tx_data == 8'h2A);
        end else begin
            prev_stall = 0;
            prev_star  = 0;
        end
    end

    task automatic expect_str(string s, string tag);
        for (int i = 0; i < s.len(); i++) begin
            exp_q.push_back(s[i]);
            tag_q.push_back(tag);
        end
    endtask

    // Behavioural model of the reply to one complete line
    task automatic model_reply(string s, string tag);
        int     n;
        bit     good;
        longint v;
        longint mult;
        string  body;
        n    = s.len();
        good = 0;
        v    = 0;
        if (n > 0 && n <= 12) begin
            if (s == "READ") begin
                expect_str($sformatf("%07dKHz%c%c*", model_freq, 8'h0D, 8'h0A), tag);
                return;
            end
            if (s == "SAVE") begin
                model_saves++;
                expect_str("*", tag);
                return;
            end
            mult = 1;
            body = s;
            if (s[n-1] == "M") begin
                mult = 1000;
                body = s.substr(0, n - 2);
            end else if (s[n-1] == "K") begin
                body = s.substr(0, n - 2);
            end
            if (body.len() >= 1 && body.len() <= 7) begin
                good = 1;
                for (int i = 0; i < body.len(); i++) begin
                    if (body[i] < "0" || body[i] > "9") good = 0;
                    else v = v * 10 + (body[i] - "0");
                end
                v = v * mult;
                if (v < 50000 || v > 3000000) good = 0;
            end
        end
        if (good) begin
            model_freq = int'(v);
            expect_str("*", tag);
        end else begin
            expect_str($sformatf("INVALID DATA%c%c*", 8'h0D, 8'h0A), tag);
        end
    endtask

    task automatic send_byte(byte unsigned c);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_line(string s, string tag);
        bit foreign;
        foreign = (s.len() > 0) && (s[0] == "$");
        cur_tag = foreign ? "R8" : tag;
        for (int i = 0; i < s.len(); i++) begin
            if (!foreign) begin
                exp_q.push_back(s[i]);
                tag_q.push_back("R1");
            end
            send_byte(s[i]);
        end
        if (!foreign) begin
            exp_q.push_back(8'h0D);
            tag_q.push_back("R1");
            model_reply(s, tag);
        end
        send_byte(8'h0D);
        do @(negedge clk); while (exp_q.size() != 0 || !rx_ready);
        repeat (3) @(negedge clk);
        #1;
        check(exp_q.size() == 0, cur_tag, "missing tx bytes", exp_q.size(), 0);
        check(freq_khz == model_freq, cur_tag, "frequency", freq_khz, model_freq);
        check(seen_saves == model_saves, "R7", "save pulse count", seen_saves, model_saves);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R11 reset state
        check(freq_khz == 22'd1000000, "R11", "reset frequency", freq_khz, 1000000);
        check(tx_valid == 1'b0, "R11", "reset tx_valid", tx_valid, 0);
        check(rx_ready == 1'b1, "R11", "reset rx_ready", rx_ready, 1);
        check(save_pulse == 1'b0, "R11", "reset save_pulse", save_pulse, 0);

        send_line("READ", "R6");
        send_line("2450M", "R2");
        send_line("READ", "R6");
        send_line("2400002K", "R3");
        rdy_mode = 1;
        send_line("123456", "R3");
        send_line("0050000", "R4");
        send_line("READ", "R6");
        send_line("49999", "R4");
        send_line("3000000K", "R4");
        send_line("3000001", "R4");
        send_line("3001M", "R4");
        send_line("3M", "R4");
        send_line("50M", "R2");
        send_line("12345678", "R4");
        rdy_mode = 2;
        send_line("read", "R5");
        send_line("", "R5");
        send_line("12K5", "R5");
        send_line("K", "R5");
        send_line("24M0", "R5");
        send_line("2450m", "R5");
        send_line("3000M", "R2");
        send_line("SAVE", "R7");
        send_line("$ADJ_100", "R8");
        send_line("$STAT", "R8");
        send_line("READ", "R8");
        rdy_mode = 0;
        send_line("AAAAAAAAAAAAA", "R9");
        send_line("11111111111111111111", "R9");
        send_line("777K", "R4");
        send_line("SAVE", "R7");
        send_line("READ", "R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule